// File: doc/BRIEF.md
# Serial Command Interface for a Multiplexed Display Controller

This block is the serial slave at the front of a multiplexed display controller. A host drives a strobe, a serial clock and a data line. The block samples bits on the rising serial clock, least significant bit first, and groups them into bytes. The strobe frames each transaction. The first byte after the strobe falls is a command, and every later byte in the same transaction is data.

Commands fall into four classes, chosen by the top two bits of the byte. They set the digit count, pick where data bytes go, load the display memory address, and set brightness and the display enable. Data bytes are written into a 36-byte display memory or into a 4-bit LED port. A data-setting command can also start a read. In a read, key-scan bytes supplied from outside are shifted out on an open-drain data-out line. That line is modelled here as a pull-low enable.

All serial pins are brought into the system clock domain through synchronizers and handled with edge detection. The configuration the block holds is driven out as plain outputs for the display multiplexer and the key scanner.

Top module: `vfd_ser_ctrl`

## Requirements
- R1: Data bits are taken on the rising serial clock, least significant bit first. A byte is complete on the eighth rising edge of a transaction's byte group.
- R2: Serial clock edges have no effect while the strobe is high. Either strobe edge clears the byte framing, so a partial byte is dropped and all earlier settings stay as they were.
- R3: The first byte after the strobe falls is a command, and its bits 7:6 pick the class: 00 digit mode, 01 data setting, 10 display control, 11 address. Later bytes in the same transaction are data.
- R4: In data mode 00 (bits 1:0 of the data-setting command), each data byte is written to display memory at the current address. The address then goes up by one, unless bit 2 of the data-setting command was 1, which holds it fixed.
- R5: An address command loads the address from its bits 5:0. While the address is 36 or above, data bytes cause no memory write and no increment, until a valid address is loaded.
- R6: In data mode 01, a data byte loads `led_out` from its low 4 bits, and a 1 drives that output high. In data mode 11, data bytes change nothing.
- R7: A display control command sets `cfg_dim` from bits 2:0 and `cfg_disp_on` from bit 3, and starts key scanning (`cfg_scan_run` = 1).
- R8: A digit-mode command selects 12 digits when bit 3 is 1, and otherwise bits 2:0 plus 4 digits. If that differs from the current count, the count is updated and the display and key scanning are both turned off. A command naming the current count changes nothing.
- R9: Bit 3 of the data-setting command sets `cfg_test`.
- R10: After a data-setting command with mode 10, each following 8-clock group shifts out key byte k, starting at k = 0 and wrapping after the last byte. Bit j is presented after the falling serial clock edge of the group's clock j+1. Every new transaction restarts at byte 0.
- R11: `sdo_pull_low` is 1 only while a read is in progress and the bit being presented is 0. It is released before the first read bit and on any strobe edge.
- R12: After reset: 12 digits, memory write mode, auto-increment, normal mode, address 0, dimming 0, display off, scanning stopped, LED outputs low, data-out released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_stb | input | 1 | Strobe; low frames a transaction |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_din | input | 1 | Serial data in |
| key_in | input | KEY_BYTES*8 | Key-scan bytes, byte k in bits 8k+7:8k |
| sdo_pull_low | output | 1 | 1 pulls the data-out line low |
| mem_we | output | 1 | Display memory write strobe, one cycle |
| mem_addr | output | ADDR_W | Display memory write address |
| mem_wdata | output | 8 | Display memory write data |
| led_out | output | LED_W | LED port levels |
| cfg_digits | output | 4 | Selected digit count (4 to 12) |
| cfg_dim | output | 3 | Dimming code |
| cfg_disp_on | output | 1 | Display enable |
| cfg_scan_run | output | 1 | Key scanning enabled |
| cfg_test | output | 1 | Test mode flag |

## Verification
The hardest state to reach from the pins is a read that has wrapped past the last key byte. It needs a read command followed by more 8-clock groups than there are key bytes, all inside one strobe-low window, and then a fresh transaction to show that the pointer restarts. The bench builds this from bit-level clock and data tasks. It also sweeps every address value, including the out-of-range ones, every digit-mode code and every display-control code. For each code it computes the expected effect directly from the field values.

// File: rtl/vfd_ser_pkg.sv
package vfd_ser_pkg;

   typedef enum logic [1:0] {
      CLS_MODE = 2'b00,
      CLS_DATA = 2'b01,
      CLS_CTRL = 2'b10,
      CLS_ADDR = 2'b11
   } cmd_class_e;

   typedef enum logic [1:0] {
      DM_MEM  = 2'b00,
      DM_LED  = 2'b01,
      DM_KEY  = 2'b10,
      DM_NONE = 2'b11
   } data_mode_e;

   localparam int BYTE_W = 8;

   // digit count selected by a mode code
   function automatic logic [3:0] digits_of(input logic [3:0] code);
      if (code[3]) return 4'd12;
      return {1'b0, code[2:0]} + 4'd4;
   endfunction

endpackage

// File: rtl/vfd_pin_sync.sv
module vfd_pin_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic prev;

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("vfd_pin_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign lvl = pin_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{RESET_VAL}};
            end else begin
               chain[0] <= pin_in;
               for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign lvl = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RESET_VAL;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

endmodule

// File: rtl/vfd_ser_shift.sv
module vfd_ser_shift
   import vfd_ser_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_lvl,
   input  logic              stb_edge,
   input  logic              clk_rise,
   input  logic              din_lvl,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_val,
   output logic              byte_first,
   output logic [2:0]        bit_cnt
);
   logic [BYTE_W-1:0] shreg;
   logic              seen_cmd;
   logic [BYTE_W-1:0] shifted;

   assign shifted = {din_lvl, shreg[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         seen_cmd   <= 1'b0;
         bit_cnt    <= '0;
         byte_vld   <= 1'b0;
         byte_val   <= '0;
         byte_first <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (stb_edge) begin
            bit_cnt  <= '0;
            seen_cmd <= 1'b0;
         end else if (clk_rise && !stb_lvl) begin
            shreg <= shifted;
            if (bit_cnt == 3'd7) begin
               byte_vld   <= 1'b1;
               byte_val   <= shifted;
               byte_first <= ~seen_cmd;
               seen_cmd   <= 1'b1;
               bit_cnt    <= '0;
            end else begin
               bit_cnt <= bit_cnt + 3'd1;
            end
         end
      end
   end

   // R2: once strobe is high the framing stays cleared
   p_ignore_when_high_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      stb_lvl |=> (bit_cnt == 3'd0));

   // R1: a byte takes eight serial edges, never two in a row
   p_byte_spacing_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

endmodule

// File: rtl/vfd_cmd_regs.sv
module vfd_cmd_regs
   import vfd_ser_pkg::*;
#(
   parameter int MEM_BYTES = 36,
   parameter int ADDR_W    = 6,
   parameter int LED_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_val,
   input  logic              byte_first,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic [LED_W-1:0]  led_out,
   output logic [3:0]        cfg_digits,
   output logic [2:0]        cfg_dim,
   output logic              cfg_disp_on,
   output logic              cfg_scan_run,
   output logic              cfg_test,
   output logic              rd_start
);
   localparam int ADDR_FIELD = 6;

   generate
      if (ADDR_W > ADDR_FIELD || ADDR_W < 1) begin : g_bad_addr
         $error("vfd_cmd_regs: ADDR_W must be 1..6");
      end
      if (MEM_BYTES < 1 || MEM_BYTES > (1 << ADDR_W)) begin : g_bad_mem
         $error("vfd_cmd_regs: MEM_BYTES out of range for ADDR_W");
      end
      if (LED_W < 1 || LED_W > BYTE_W) begin : g_bad_led
         $error("vfd_cmd_regs: LED_W must be 1..8");
      end
   endgenerate

   cmd_class_e        cls;
   data_mode_e        dmode;
   logic              addr_hold;
   logic [ADDR_W-1:0] addr;
   logic              addr_ok;
   logic [3:0]        new_digits;

   assign cls        = cmd_class_e'(byte_val[7:6]);
   assign addr_ok    = ({1'b0, addr} < (ADDR_W+1)'(MEM_BYTES));
   assign new_digits = digits_of(byte_val[3:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dmode        <= DM_MEM;
         addr_hold    <= 1'b0;
         addr         <= '0;
         mem_we       <= 1'b0;
         mem_addr     <= '0;
         mem_wdata    <= '0;
         led_out      <= '0;
         cfg_digits   <= 4'd12;
         cfg_dim      <= 3'd0;
         cfg_disp_on  <= 1'b0;
         cfg_scan_run <= 1'b0;
         cfg_test     <= 1'b0;
         rd_start     <= 1'b0;
      end else begin
         mem_we   <= 1'b0;
         rd_start <= 1'b0;
         if (byte_vld && byte_first) begin
            unique case (cls)
               CLS_MODE: begin
                  if (new_digits != cfg_digits) begin
                     cfg_digits   <= new_digits;
                     cfg_disp_on  <= 1'b0;
                     cfg_scan_run <= 1'b0;
                  end
               end
               CLS_DATA: begin
                  dmode     <= data_mode_e'(byte_val[1:0]);
                  addr_hold <= byte_val[2];
                  cfg_test  <= byte_val[3];
                  rd_start  <= (byte_val[1:0] == DM_KEY);
               end
               CLS_CTRL: begin
                  cfg_dim      <= byte_val[2:0];
                  cfg_disp_on  <= byte_val[3];
                  cfg_scan_run <= 1'b1;
               end
               CLS_ADDR: begin
                  addr <= byte_val[ADDR_W-1:0];
               end
               default: ;
            endcase
         end else if (byte_vld) begin
            unique case (dmode)
               DM_MEM: begin
                  if (addr_ok) begin
                     mem_we    <= 1'b1;
                     mem_addr  <= addr;
                     mem_wdata <= byte_val;
                     if (!addr_hold) addr <= addr + 1'b1;
                  end
               end
               DM_LED:  led_out <= byte_val[LED_W-1:0];
               default: ;
            endcase
         end
      end
   end

   // R5: no write ever reaches an address beyond the memory
   p_no_write_oob_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ({1'b0, mem_addr} < (ADDR_W+1)'(MEM_BYTES)));

   // R8: a change of digit count leaves display and scanning off
   p_mode_change_off_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_digits != $past(cfg_digits)) |-> (!cfg_disp_on && !cfg_scan_run));

   // R8: digit count stays inside 4..12
   p_digits_range_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_digits >= 4'd4) && (cfg_digits <= 4'd12));

endmodule

// File: rtl/vfd_key_reader.sv
module vfd_key_reader #(
   parameter int KEY_BYTES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   txn_reset,
   input  logic                   rd_start,
   input  logic                   byte_vld,
   input  logic                   clk_fall,
   input  logic                   stb_lvl,
   input  logic [2:0]             bit_cnt,
   input  logic [KEY_BYTES*8-1:0] key_in,
   output logic                   pull_low
);
   localparam int PTR_W = $clog2(KEY_BYTES);

   generate
      if (KEY_BYTES < 2) begin : g_bad_keys
         $error("vfd_key_reader: KEY_BYTES must be at least 2");
      end
   endgenerate

   logic             rd_active;
   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W+2:0] idx;
   logic [PTR_W-1:0] ptr_next;

   assign idx      = {rd_ptr, bit_cnt};
   assign ptr_next = (rd_ptr == PTR_W'(KEY_BYTES-1)) ? '0 : rd_ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_active <= 1'b0;
         rd_ptr    <= '0;
         pull_low  <= 1'b0;
      end else if (txn_reset) begin
         rd_active <= 1'b0;
         rd_ptr    <= '0;
         pull_low  <= 1'b0;
      end else if (rd_start) begin
         rd_active <= 1'b1;
         rd_ptr    <= '0;
         pull_low  <= 1'b0;
      end else if (rd_active) begin
         if (clk_fall && !stb_lvl) pull_low <= ~key_in[idx];
         if (byte_vld)             rd_ptr   <= ptr_next;
      end
   end

   // R11: a strobe edge releases the line on the next cycle
   p_release_on_stb_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      txn_reset |=> !pull_low);

   // R11: the line is driven only inside a read
   p_release_idle_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_active && !$past(rd_active)) |-> !pull_low);

endmodule

// File: rtl/vfd_ser_ctrl.sv
module vfd_ser_ctrl
   import vfd_ser_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MEM_BYTES   = 36,
   parameter int ADDR_W      = 6,
   parameter int KEY_BYTES   = 4,
   parameter int LED_W       = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ser_stb,
   input  logic                   ser_clk,
   input  logic                   ser_din,
   input  logic [KEY_BYTES*8-1:0] key_in,
   output logic                   sdo_pull_low,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [BYTE_W-1:0]      mem_wdata,
   output logic [LED_W-1:0]       led_out,
   output logic [3:0]             cfg_digits,
   output logic [2:0]             cfg_dim,
   output logic                   cfg_disp_on,
   output logic                   cfg_scan_run,
   output logic                   cfg_test
);
   logic stb_lvl, stb_rise, stb_fall, stb_edge;
   logic sclk_lvl, sclk_rise, sclk_fall;
   logic din_lvl, din_rise, din_fall;
   logic              byte_vld, byte_first, rd_start;
   logic [BYTE_W-1:0] byte_val;
   logic [2:0]        bit_cnt;

   vfd_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_stb (
      .clk(clk), .rst_n(rst_n), .pin_in(ser_stb),
      .lvl(stb_lvl), .rise(stb_rise), .fall(stb_fall));

   vfd_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_clk (
      .clk(clk), .rst_n(rst_n), .pin_in(ser_clk),
      .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

   vfd_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_sync_din (
      .clk(clk), .rst_n(rst_n), .pin_in(ser_din),
      .lvl(din_lvl), .rise(din_rise), .fall(din_fall));

   assign stb_edge = stb_rise | stb_fall;

   vfd_ser_shift i_shift (
      .clk(clk), .rst_n(rst_n),
      .stb_lvl(stb_lvl), .stb_edge(stb_edge),
      .clk_rise(sclk_rise), .din_lvl(din_lvl),
      .byte_vld(byte_vld), .byte_val(byte_val),
      .byte_first(byte_first), .bit_cnt(bit_cnt));

   vfd_cmd_regs #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W), .LED_W(LED_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .byte_vld(byte_vld), .byte_val(byte_val), .byte_first(byte_first),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .led_out(led_out), .cfg_digits(cfg_digits), .cfg_dim(cfg_dim),
      .cfg_disp_on(cfg_disp_on), .cfg_scan_run(cfg_scan_run),
      .cfg_test(cfg_test), .rd_start(rd_start));

   vfd_key_reader #(.KEY_BYTES(KEY_BYTES)) i_reader (
      .clk(clk), .rst_n(rst_n),
      .txn_reset(stb_edge), .rd_start(rd_start), .byte_vld(byte_vld),
      .clk_fall(sclk_fall), .stb_lvl(stb_lvl), .bit_cnt(bit_cnt),
      .key_in(key_in), .pull_low(sdo_pull_low));

   // R3: a read can only start from the command byte of a transaction
   p_read_from_cmd_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> $past(byte_vld && byte_first));

   // R12: nothing is written before any data byte arrived
   p_no_spurious_write_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(byte_vld && !byte_first));

   // din edges are not used beyond level sampling
   logic unused_din_edges;
   assign unused_din_edges = din_rise ^ din_fall ^ sclk_lvl;

endmodule

// File: tb/test_vfd_ser_ctrl.sv
module test_vfd_ser_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int KEYB       = 4;
   localparam int MEMB       = 36;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_stb = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
   logic [KEYB*8-1:0] key_in = '0;
   logic sdo_pull_low, mem_we, cfg_disp_on, cfg_scan_run, cfg_test;
   logic [5:0] mem_addr;
   logic [7:0] mem_wdata;
   logic [3:0] led_out, cfg_digits;
   logic [2:0] cfg_dim;

   int checks = 0, errors = 0, we_count = 0, cyc = 0;
   int last_addr = -1, last_data = -1;

   always #(CLK_PERIOD/2) clk = ~clk;

   vfd_ser_ctrl i_vfd_ser_ctrl (
      .clk(clk), .rst_n(rst_n), .ser_stb(ser_stb), .ser_clk(ser_clk),
      .ser_din(ser_din), .key_in(key_in), .sdo_pull_low(sdo_pull_low),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .led_out(led_out), .cfg_digits(cfg_digits), .cfg_dim(cfg_dim),
      .cfg_disp_on(cfg_disp_on), .cfg_scan_run(cfg_scan_run), .cfg_test(cfg_test));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_we) begin
         we_count  <= we_count + 1;
         last_addr <= int'(mem_addr);
         last_data <= int'(mem_wdata);
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         ser_clk = 1'b0; ser_din = b[i];
         wait_cyc(HALF);
         ser_clk = 1'b1;
         wait_cyc(HALF);
      end
   endtask

   task automatic stb_low();  ser_stb = 1'b0; wait_cyc(HALF); endtask
   task automatic stb_high(); ser_stb = 1'b1; wait_cyc(2*HALF); endtask

   task automatic txn1(input logic [7:0] a);
      stb_low(); send_bits(a, 8); stb_high();
   endtask
   task automatic txn2(input logic [7:0] a, input logic [7:0] b);
      stb_low(); send_bits(a, 8); send_bits(b, 8); stb_high();
   endtask

   // read n bytes after a read command; compare each bit
   task automatic read_bytes(input int n, input string tag);
      int bad = 0;
      stb_low(); send_bits(8'h42, 8);
      check(sdo_pull_low == 1'b0, "R11 released before first bit", sdo_pull_low, 0);
      for (int k = 0; k < n; k++) begin
         for (int j = 0; j < 8; j++) begin
            logic expb;
            expb = key_in[(k % KEYB)*8 + j];
            ser_clk = 1'b0;
            wait_cyc(HALF);
            if (sdo_pull_low != ~expb) bad++;
            ser_clk = 1'b1;
            wait_cyc(HALF);
         end
      end
      stb_high();
      check(bad == 0, tag, bad, 0);
      check(sdo_pull_low == 1'b0, "R11 released after strobe", sdo_pull_low, 0);
   endtask

   initial begin
      wait_cyc(150000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int wc, exp_dig, prev_dig;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);
      // R12 reset state
      check(cfg_digits == 4'd12, "R12 digits", cfg_digits, 12);
      check(cfg_dim == 3'd0, "R12 dim", cfg_dim, 0);
      check(!cfg_disp_on && !cfg_scan_run, "R12 off", cfg_disp_on, 0);
      check(led_out == 4'd0 && !cfg_test, "R12 led/test", led_out, 0);
      check(!sdo_pull_low, "R12 dout", sdo_pull_low, 0);
      // R12/R4 default mode writes memory at 0 with increment
      stb_low(); send_bits(8'hA7, 8); stb_high();
      txn2(8'hC0, 8'h11);
      check(we_count == 1 && last_addr == 0 && last_data == 8'h11, "R12 default write", last_addr, 0);

      // R5 address sweep over all 64 codes
      txn1(8'h40);
      for (int a = 0; a < 64; a++) begin
         wc = we_count;
         txn2(8'hC0 | 8'(a), 8'(a) ^ 8'h5A);
         if (a < MEMB)
            check(we_count == wc + 1 && last_addr == a && last_data == ((a ^ 8'h5A) & 8'hFF),
                  "R5 valid address write", last_addr, a);
         else
            check(we_count == wc, "R5 out-of-range ignored", we_count - wc, 0);
      end

      // R4 increment across the top: 22h, 23h written, third dropped
      wc = we_count;
      stb_low(); send_bits(8'hC0 | 8'h22, 8); send_bits(8'h01, 8);
      send_bits(8'h02, 8); send_bits(8'h03, 8); stb_high();
      check(we_count == wc + 2 && last_addr == 35 && last_data == 2, "R4 increment stops at end", we_count - wc, 2);

      // R4 fixed address
      txn1(8'h44);
      wc = we_count;
      stb_low(); send_bits(8'hC5, 8); send_bits(8'h31, 8);
      send_bits(8'h32, 8); send_bits(8'h33, 8); stb_high();
      check(we_count == wc + 3 && last_addr == 5 && last_data == 8'h33, "R4 fixed address", last_addr, 5);

      // R6 LED port, low nibble only
      txn2(8'h41, 8'hF5);
      check(led_out == 4'h5, "R6 led low nibble", led_out, 5);
      txn2(8'h41, 8'h3A);
      check(led_out == 4'hA, "R6 led update", led_out, 10);
      // R6 mode 11 has no effect
      wc = we_count;
      txn2(8'h43, 8'h07);
      check(led_out == 4'hA && we_count == wc, "R6 mode 11 ignored", led_out, 10);

      // R9 test flag
      txn1(8'h48);
      check(cfg_test == 1'b1, "R9 test set", cfg_test, 1);
      txn1(8'h40);
      check(cfg_test == 1'b0, "R9 test clear", cfg_test, 0);

      // R7 display control sweep
      for (int n = 0; n < 16; n++) begin
         txn1(8'h80 | 8'(n));
         check(cfg_dim == 3'(n) && cfg_disp_on == n[3] && cfg_scan_run,
               "R7 control fields", {cfg_disp_on, cfg_dim}, n);
      end

      // R2 partial byte discarded: half of a control byte
      txn1(8'h8B);
      stb_low(); send_bits(8'h84, 4); stb_high();
      check(cfg_dim == 3'd3 && cfg_disp_on, "R2 partial byte dropped", cfg_dim, 3);
      // R2 clocks while strobe high ignored, then framing still aligned
      send_bits(8'hFF, 5);
      txn1(8'h8D);
      check(cfg_dim == 3'd5 && cfg_disp_on, "R2 clocks with strobe high ignored", cfg_dim, 5);
      // R3 second byte in a transaction is data not command
      txn1(8'h41);
      txn2(8'h41, 8'h86);
      check(cfg_dim == 3'd5 && led_out == 4'h6, "R3 later byte is data", led_out, 6);

      // R8 mode sweep
      prev_dig = cfg_digits;
      for (int v = 0; v < 16; v++) begin
         txn1(8'h8F);
         txn1(8'(v));
         exp_dig = v[3] ? 12 : (v & 7) + 4;
         check(cfg_digits == 4'(exp_dig), "R8 digit count", cfg_digits, exp_dig);
         check(cfg_disp_on == (exp_dig == prev_dig) && cfg_scan_run == (exp_dig == prev_dig),
               "R8 off on change only", cfg_disp_on, (exp_dig == prev_dig));
         prev_dig = exp_dig;
      end

      // R10/R11 key read with wrap, then restart
      key_in = 32'h96C3_5AA1;
      read_bytes(KEYB + 2, "R10 key bytes with wrap");
      key_in = 32'h0F0F_E17E;
      read_bytes(1, "R10 pointer restarts");
      check(cfg_digits == 4'd12 && led_out == 4'h6, "R10 read leaves settings", led_out, 6);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule